// File: doc/BRIEF.md
# DMA Transfer Event Generator

This block watches the progress of one DMA channel and emits the transfer-complete and half-transfer pulses at a granularity chosen per channel run. The granularity can be a single block, a repeated block, one linked-list item, or the whole channel. The data mover reports its progress through three strobes: a beat has finished, a block has ended, or a linked-list item has been loaded. With each strobe it also presents the remaining byte count and the remaining repeat count. When an item is loaded, the mover also supplies that item's next-link address and its update-flag bits.

The event-mode code is captured on the cycle the channel enable rises, and it stays fixed until the enable drops. The byte count and repeat count present on that cycle describe the directly programmed first item, and so do the link fields. Each pulse appears on the clock edge that follows the strobe causing it. The parameter `HAS_RPT` selects whether the channel supports repeated blocks.

Top module: `dma_evt_gen`

## Requirements
- R1: While reset is held, and after it is released, `tc_o` and `ht_o` are low until an event is caused.
- R2: Mode code 0 (block) pulses `tc_o` one cycle after every `blk_end_i`, whatever the repeat count.
- R3: Mode code 1 (repeated block) pulses `tc_o` only at a `blk_end_i` with `brc_i` equal to 0. Its half threshold is taken over the whole repeated block: remaining = `brc_i`·length + `bndt_i`, where length is the block length.
- R4: In modes 0 and 1, an item whose byte count is 0 when it is captured produces no `tc_o` and no `ht_o`.
- R5: Mode code 2 (item) pulses `tc_o` when `lli_load_i` completes the update that ends the current item. For an item that is last, it pulses `tc_o` at the end of the item's data instead. `ht_o` marks the midpoint of the item's data.
- R6: In mode 2, a first item captured with byte count 0 gives no `ht_o`, and gives `tc_o` when the next item's load finishes.
- R7: Mode code 3 (channel) gives events only inside the last item. An item is last when its link address is 0 and all its update bits are 0. A list that never reaches such an item gives no events.
- R8: The half threshold is the start count of the unit shifted right by one. `ht_o` fires once per unit, on the first beat where the remaining count is at or below that threshold.
- R9: `tc_o` and `ht_o` are never high in the same cycle. When both would fire, `tc_o` wins and the half event of that unit is consumed.
- R10: The mode code is sampled when the enable rises. Changes on `mode_i` while the channel stays enabled have no effect.
- R11: Strobes are ignored while `chan_en_i` is low and on the cycle it rises. An event appears exactly one cycle after its strobe.
- R12: With `HAS_RPT` = 0, mode 1 behaves as mode 0, and `brc_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Event granularity code |
| bndt_i | input | CNT_W | Remaining bytes in the current block |
| brc_i | input | RPT_W | Repeats still to run after the current block |
| beat_done_i | input | 1 | A data beat finished; `bndt_i` shows the count after it |
| blk_end_i | input | 1 | The current block finished |
| lli_load_i | input | 1 | A linked-list item load finished |
| lli_la_i | input | LA_W | Next-link address of the item being captured |
| lli_upd_i | input | UPD_W | Update-flag bits of the item being captured |
| tc_o | output | 1 | Transfer-complete pulse |
| ht_o | output | 1 | Half-transfer pulse |

## Verification
The half event and the complete event can fall in the same cycle. This happens when the final beat of a unit crosses the half threshold, as in a one-byte block whose threshold is zero. The bench provokes this by raising `beat_done_i` and `blk_end_i` together on that last beat. It then judges that only `tc_o` pulses. A second collision, the half threshold crossed exactly at a non-final block end in mode 1, must give `ht_o` alone.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  typedef enum logic [1:0] {
    EVT_BLOCK = 2'b00,
    EVT_RPT   = 2'b01,
    EVT_ITEM  = 2'b10,
    EVT_CHAN  = 2'b11
  } evt_mode_e;
endpackage

// File: rtl/dma_evt_ctx.sv
module dma_evt_ctx
  import dma_evt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RPT_W   = 4,
  parameter int LA_W    = 14,
  parameter int UPD_W   = 8,
  parameter bit HAS_RPT = 1'b1,
  localparam int TOT_W  = CNT_W + RPT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             act_i,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] bndt_i,
  input  logic [RPT_W-1:0] brc_i,
  input  logic [LA_W-1:0]  la_i,
  input  logic [UPD_W-1:0] upd_i,
  output evt_mode_e        mode_o,
  output logic [CNT_W-1:0] blen_o,
  output logic [TOT_W-1:0] total_o,
  output logic             null_o,
  output logic             last_o
);
  evt_mode_e        mode_q, eff_mode;
  logic [CNT_W-1:0] blen_q;
  logic [TOT_W-1:0] tot_q, tot_in;
  logic             null_q, last_q, last_in;

  // without repeat support the repeated-block mode folds onto block mode
  always_comb begin
    eff_mode = evt_mode_e'(mode_i);
    if (!HAS_RPT && eff_mode == EVT_RPT) eff_mode = EVT_BLOCK;
  end

  generate
    if (HAS_RPT) begin : g_rpt
      assign tot_in = TOT_W'(bndt_i) * TOT_W'({1'b0, brc_i} + 1'b1);
    end else begin : g_norpt
      logic unused_brc;
      assign unused_brc = ^brc_i;
      assign tot_in     = TOT_W'(bndt_i);
    end
  endgenerate

  assign last_in = (la_i == '0) && (upd_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= EVT_BLOCK;
      blen_q <= '0;
      tot_q  <= '0;
      null_q <= 1'b0;
      last_q <= 1'b0;
    end else if (cap_i) begin
      mode_q <= eff_mode;
      blen_q <= bndt_i;
      tot_q  <= tot_in;
      null_q <= (bndt_i == '0);
      last_q <= last_in;
    end else if (load_i) begin
      blen_q <= bndt_i;
      tot_q  <= tot_in;
      null_q <= (bndt_i == '0);
      last_q <= last_in;
    end
  end

  assign mode_o  = mode_q;
  assign blen_o  = blen_q;
  assign total_o = tot_q;
  assign null_o  = null_q;
  assign last_o  = last_q;

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> $stable(mode_q)); // R10

endmodule

// File: rtl/dma_evt_remain.sv
module dma_evt_remain #(
  parameter int CNT_W   = 16,
  parameter int RPT_W   = 4,
  parameter bit HAS_RPT = 1'b1,
  localparam int TOT_W  = CNT_W + RPT_W
) (
  input  logic [CNT_W-1:0] bndt_i,
  input  logic [RPT_W-1:0] brc_i,
  input  logic [CNT_W-1:0] blen_i,
  output logic [TOT_W-1:0] rem_o,
  output logic             brc_zero_o
);
  generate
    if (HAS_RPT) begin : g_rpt
      assign rem_o      = TOT_W'(brc_i) * TOT_W'(blen_i) + TOT_W'(bndt_i);
      assign brc_zero_o = (brc_i == '0);
    end else begin : g_norpt
      logic unused_rb;
      assign unused_rb  = ^{brc_i, blen_i};
      assign rem_o      = TOT_W'(bndt_i);
      assign brc_zero_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dma_evt_fire.sv
module dma_evt_fire
  import dma_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RPT_W  = 4,
  localparam int TOT_W = CNT_W + RPT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             cap_i,
  input  logic             beat_i,
  input  logic             blk_end_i,
  input  logic             load_i,
  input  evt_mode_e        mode_i,
  input  logic [CNT_W-1:0] blen_i,
  input  logic [TOT_W-1:0] total_i,
  input  logic             null_i,
  input  logic             last_i,
  input  logic [TOT_W-1:0] rem_i,
  input  logic [CNT_W-1:0] bndt_i,
  input  logic             brc_zero_i,
  output logic             tc_o,
  output logic             ht_o
);
  logic [TOT_W-1:0] unit_start, unit_rem;
  logic             half_gate, ht_hit, tc_hit, data_end, unit_new;
  logic             half_done_q, tc_q, ht_q;

  assign unit_start = (mode_i == EVT_BLOCK) ? TOT_W'(blen_i) : total_i;
  assign unit_rem   = (mode_i == EVT_BLOCK) ? TOT_W'(bndt_i) : rem_i;
  assign half_gate  = (mode_i == EVT_CHAN) ? last_i : 1'b1;

  assign ht_hit = act_i && beat_i && !half_done_q && (unit_start != '0) &&
                  half_gate && (unit_rem <= (unit_start >> 1));

  assign data_end = blk_end_i && brc_zero_i && !null_i;

  always_comb begin
    unique case (mode_i)
      EVT_BLOCK: tc_hit = act_i && blk_end_i && !null_i;
      EVT_RPT:   tc_hit = act_i && data_end;
      EVT_ITEM:  tc_hit = act_i && (load_i || (data_end && last_i));
      EVT_CHAN:  tc_hit = act_i && data_end && last_i;
      default:   tc_hit = 1'b0;
    endcase
  end

  // a new unit re-arms the half detector
  assign unit_new = cap_i || (act_i && load_i) ||
                    (act_i && blk_end_i && mode_i == EVT_BLOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_done_q <= 1'b0;
      tc_q        <= 1'b0;
      ht_q        <= 1'b0;
    end else begin
      if (unit_new)    half_done_q <= 1'b0;
      else if (ht_hit) half_done_q <= 1'b1;
      tc_q <= tc_hit;
      ht_q <= ht_hit && !tc_hit;
    end
  end

  assign tc_o = tc_q;
  assign ht_o = ht_q;

  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tc_o && ht_o)); // R9
  AST_HT_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ht_o |-> $past(beat_i)); // R8
  AST_TC_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(blk_end_i || load_i)); // R5
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(act_i) |-> !(tc_o || ht_o)); // R11
  AST_NULL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (null_i && (mode_i == EVT_BLOCK || mode_i == EVT_RPT)) |=> !tc_o); // R4

endmodule

// File: rtl/dma_evt_gen.sv
module dma_evt_gen
  import dma_evt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RPT_W   = 4,
  parameter int LA_W    = 14,
  parameter int UPD_W   = 8,
  parameter bit HAS_RPT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] bndt_i,
  input  logic [RPT_W-1:0] brc_i,
  input  logic             beat_done_i,
  input  logic             blk_end_i,
  input  logic             lli_load_i,
  input  logic [LA_W-1:0]  lli_la_i,
  input  logic [UPD_W-1:0] lli_upd_i,
  output logic             tc_o,
  output logic             ht_o
);
  localparam int TOT_W = CNT_W + RPT_W;

  logic             en_q, cap, act;
  evt_mode_e        mode_q;
  logic [CNT_W-1:0] blen;
  logic [TOT_W-1:0] total, rem;
  logic             item_null, item_last, brc_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= chan_en_i;
  end

  assign cap = chan_en_i && !en_q;
  assign act = chan_en_i && en_q;

  dma_evt_ctx #(
    .CNT_W(CNT_W), .RPT_W(RPT_W), .LA_W(LA_W), .UPD_W(UPD_W), .HAS_RPT(HAS_RPT)
  ) u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .act_i   (act),
    .load_i  (act && lli_load_i),
    .mode_i  (mode_i),
    .bndt_i  (bndt_i),
    .brc_i   (brc_i),
    .la_i    (lli_la_i),
    .upd_i   (lli_upd_i),
    .mode_o  (mode_q),
    .blen_o  (blen),
    .total_o (total),
    .null_o  (item_null),
    .last_o  (item_last)
  );

  dma_evt_remain #(
    .CNT_W(CNT_W), .RPT_W(RPT_W), .HAS_RPT(HAS_RPT)
  ) u_rem (
    .bndt_i     (bndt_i),
    .brc_i      (brc_i),
    .blen_i     (blen),
    .rem_o      (rem),
    .brc_zero_o (brc_zero)
  );

  dma_evt_fire #(
    .CNT_W(CNT_W), .RPT_W(RPT_W)
  ) u_fire (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .cap_i      (cap),
    .beat_i     (beat_done_i),
    .blk_end_i  (blk_end_i),
    .load_i     (lli_load_i),
    .mode_i     (mode_q),
    .blen_i     (blen),
    .total_i    (total),
    .null_i     (item_null),
    .last_i     (item_last),
    .rem_i      (rem),
    .bndt_i     (bndt_i),
    .brc_zero_i (brc_zero),
    .tc_o       (tc_o),
    .ht_o       (ht_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !(tc_o || ht_o)); // R11

endmodule

// File: tb/dma_evt_gen_tb.sv
`timescale 1ns/1ps
module dma_evt_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_r = 1'b0;
  logic [1:0]  mode_r = '0;
  logic [15:0] bndt_r = '0;
  logic [3:0]  brc_r = '0;
  logic        beat_r = 1'b0, bend_r = 1'b0, load_r = 1'b0;
  logic [13:0] la_r = '0;
  logic [7:0]  upd_r = '0;
  logic        tc, ht, tc_nr, ht_nr;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dma_evt_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en_r), .mode_i(mode_r),
    .bndt_i(bndt_r), .brc_i(brc_r), .beat_done_i(beat_r), .blk_end_i(bend_r),
    .lli_load_i(load_r), .lli_la_i(la_r), .lli_upd_i(upd_r),
    .tc_o(tc), .ht_o(ht)
  );

  dma_evt_gen #(.HAS_RPT(1'b0)) u_dut_nr (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en_r), .mode_i(mode_r),
    .bndt_i(bndt_r), .brc_i(brc_r), .beat_done_i(beat_r), .blk_end_i(bend_r),
    .lli_load_i(load_r), .lli_la_i(la_r), .lli_upd_i(upd_r),
    .tc_o(tc_nr), .ht_o(ht_nr)
  );

  // en mode bndt brc beat bend load la upd exp_tc exp_ht req
  localparam int NV = 54;
  localparam int VECS [NV][12] = '{
    '{0,0,0,0,0,0,0,0,0,0,0,1},
    '{1,0,8,1,0,0,0,4,1,0,0,2},   // R2 block mode, two blocks of 8
    '{1,0,6,1,1,0,0,4,1,0,0,2},
    '{1,0,4,1,1,0,0,4,1,0,1,8},   // R8 at threshold 4
    '{1,0,2,1,1,0,0,4,1,0,0,8},   // R8 no second half
    '{1,0,0,1,1,1,0,4,1,1,0,2},
    '{1,0,8,0,0,0,0,4,1,0,0,2},
    '{1,0,3,0,1,0,0,4,1,0,1,2},
    '{1,0,0,0,1,1,0,4,1,1,0,2},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,1,8,1,0,0,0,4,1,0,0,3},   // R3 repeated block 2x8
    '{1,1,4,1,1,0,0,4,1,0,0,3},
    '{1,1,0,1,1,1,0,4,1,0,1,3},
    '{1,1,8,0,0,0,0,4,1,0,0,3},
    '{1,1,0,0,1,1,0,4,1,1,0,3},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,2,4,0,0,0,0,8,1,0,0,5},   // R5 item mode
    '{1,2,2,0,1,0,0,8,1,0,1,5},
    '{1,2,0,0,1,1,0,8,1,0,0,5},
    '{1,2,6,0,0,0,1,0,0,1,0,5},
    '{1,2,3,0,1,0,0,0,0,0,1,5},
    '{1,2,0,0,1,1,0,0,0,1,0,5},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,2,0,0,0,0,0,8,1,0,0,6},   // R6 empty first item
    '{1,2,0,0,1,1,0,8,1,0,0,6},
    '{1,2,4,0,0,0,1,0,0,1,0,6},
    '{1,2,2,0,1,0,0,0,0,0,1,6},
    '{1,2,0,0,1,1,0,0,0,1,0,6},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,0,0,0,0,0,0,4,1,0,0,4},   // R4 empty item, mode 0
    '{1,0,0,0,1,1,0,4,1,0,0,4},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,1,0,0,0,0,0,4,1,0,0,4},   // R4 empty item, mode 1
    '{1,1,0,0,1,1,0,4,1,0,0,4},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,3,4,0,0,0,0,8,1,0,0,7},   // R7 channel mode
    '{1,3,2,0,1,0,0,8,1,0,0,7},
    '{1,3,0,0,1,1,0,8,1,0,0,7},
    '{1,3,4,0,0,0,1,0,2,0,0,7},
    '{1,3,2,0,1,0,0,0,2,0,0,7},
    '{1,3,0,0,1,1,0,0,2,0,0,7},
    '{1,3,4,0,0,0,1,0,0,0,0,7},
    '{1,3,2,0,1,0,0,0,0,0,1,7},
    '{1,3,0,0,1,1,0,0,0,1,0,7},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,0,1,0,0,0,0,4,1,0,0,9},   // R9 one-byte block collision
    '{1,0,0,0,1,1,0,4,1,1,0,9},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{1,0,8,1,0,0,0,4,1,0,0,10},  // R10 mode changed after enable
    '{1,3,4,1,1,0,0,4,1,0,1,10},
    '{1,3,0,1,1,1,0,4,1,1,0,10},
    '{0,0,0,0,0,0,0,0,0,0,0,11},
    '{0,0,4,0,1,1,1,0,0,0,0,11},  // R11 strobes while disabled
    '{0,2,0,0,1,1,1,0,0,0,0,11}
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {tc,ht} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input int v [12]);
    en_r   = (v[0] != 0);
    mode_r = 2'(v[1]);
    bndt_r = 16'(v[2]);
    brc_r  = 4'(v[3]);
    beat_r = (v[4] != 0);
    bend_r = (v[5] != 0);
    load_r = (v[6] != 0);
    la_r   = 14'(v[7]);
    upd_r  = 8'(v[8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {tc, ht}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {tc, ht}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk($sformatf("R%0d row %0d", VECS[i][11], i), {tc, ht},
          {VECS[i][9] != 0, VECS[i][10] != 0});
    end

    // R12: no repeat support, mode 1 acts per block and ignores brc
    drive('{1,1,8,3,0,0,0,4,1,0,0,12});
    @(negedge clk);
    chk("R12 capture", {tc_nr, ht_nr}, 2'b00);
    drive('{1,1,4,3,1,0,0,4,1,0,0,12});
    @(negedge clk);
    chk("R12 half per block", {tc_nr, ht_nr}, 2'b01);
    chk("R3 half over 32 bytes not yet", {tc, ht}, 2'b00);
    drive('{1,1,0,3,1,1,0,4,1,0,0,12});
    @(negedge clk);
    chk("R12 complete at block end", {tc_nr, ht_nr}, 2'b10);
    chk("R3 no complete with repeats left", {tc, ht}, 2'b00);
    drive('{0,0,0,0,0,0,0,0,0,0,0,12});
    @(negedge clk);

    // R1: reset in the middle of a run clears state
    drive('{1,0,2,0,0,0,0,4,1,0,0,1});
    @(negedge clk);
    drive('{1,0,1,0,1,0,0,4,1,0,0,1});
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {tc, ht}, 2'b00);
    drive('{0,0,0,0,0,0,0,0,0,0,0,1});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after release", {tc, ht}, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule